// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host side of a three-wire link to a 12-bit successive-approximation converter. It divides the system clock into a data clock, drives an active-low select, and shifts in the serial stream. Each frame begins with the select going low while the data clock is low. The converter spends the first two clock periods sampling, then sends one low null bit and the result, most significant bit first. The controller skips this prefix by counting rising edges of the data clock. It assembles the word and presents it with a one-cycle valid strobe.

Three read modes are chosen at the start of each frame. The full read takes all twelve bits. The short read stops the conversion after a leading count of bits. It left-justifies those bits with zeros below and reports the count. The echo read keeps clocking after the last bit. The converter then replays bits 1 to 11 least significant first, and the controller checks that replay against the main word. The select always returns high for at least one full data-clock period between frames.

Top module: `sar_rd_top`

## Requirements
- R1: After reset, `csN` is 1, `sclk` is 0, `busy` is 0, `resultValid` is 0 and `result` is 0.
- R2: Every high and every low phase of `sclk` inside a frame lasts exactly H system cycles. H is `halfDiv`, raised to MIN_HALF (150 ns of system clock, rounded up) when `halfDiv` is smaller.
- R3: `csN` falls while `sclk` is low, and `sclk` stays low whenever `csN` is high. A frame has 15 rising edges in full mode, 3+n in short mode, and 26 in echo mode.
- R4: The `mode` encoding is 0 = full, 1 = short, 2 = echo, and 3 behaves as full. In full mode the bits sampled on rising edges 4 to 15 form `result`, first bit in bit 11, and `resultLen` is 12.
- R5: In short mode the n bits sampled on rising edges 4 to 3+n fill `result` from bit 11 downward, the lower bits are 0, and `resultLen` is n. A `shortLen` of 0 counts as 1, and a value above 12 counts as 12.
- R6: `frameErr` is 1 when the bit sampled on rising edge 3 (the null bit) was 1, and 0 otherwise.
- R7: In echo mode, the bits sampled on rising edges 16 to 26 are bits 1 to 11 of the word, in that order. `echoErr` is 1 when any of them differs from the same bit of `result`. `echoErr` is 0 in the other modes.
- R8: A `start` pulse while `busy` is 1 is ignored. `csN` stays high for at least 2H cycles between frames, and `busy` is 0 only while `csN` is high and `sclk` is low.
- R9: `resultValid` is high for exactly one cycle, the first cycle in which `csN` is high again after a frame. `result` and the flags hold their values until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one frame (taken only when idle) |
| mode | input | 2 | Read mode: 0 full, 1 short, 2 echo, 3 full |
| shortLen | input | 4 | Bit count for short mode |
| halfDiv | input | 8 | Requested half-period of the data clock, in system cycles |
| sdi | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low converter select |
| sclk | output | 1 | Data clock to the converter |
| busy | output | 1 | A frame or the gap after it is in progress |
| result | output | 12 | Assembled, left-justified word |
| resultLen | output | 4 | Number of valid leading bits in `result` |
| resultValid | output | 1 | One-cycle strobe for a new result |
| frameErr | output | 1 | Null bit was not low |
| echoErr | output | 1 | Replayed bits disagree with the word |

## Verification
The hardest cases to reach are the error paths. The converter never produces a high null bit or a corrupt replay on its own. The bench's converter model therefore takes a per-frame override that drives the null bit high, or flips a single replayed bit at a chosen falling edge. The model counts falling edges from the select going low, so both faults land at the exact bit position under test. A second `start` is pulsed in the middle of a frame to show that it launches no extra frame. `halfDiv` values of 0 and 1 show that the clamp holds each clock phase at the minimum length.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [1:0] {
    MODE_FULL  = 2'd0,
    MODE_SHORT = 2'd1,
    MODE_ECHO  = 2'd2,
    MODE_ALT   = 2'd3
  } rdMode_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clear;
    logic capNull;
    logic capData;
    logic capEcho;
    logic finish;
  } rdStrobe_t;

endpackage

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl
  import sar_rd_pkg::*;
#(
  parameter int WORD_W       = 12,
  parameter int DIV_W        = 8,
  parameter int MIN_HALF     = 15,
  parameter int PREFIX_RISES = 3,
  parameter int LEN_W        = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  rdMode_e          mode,
  input  logic [LEN_W-1:0] shortLen,
  input  logic [DIV_W-1:0] halfDiv,
  output logic             csN,
  output logic             sclk,
  output logic             busy,
  output rdStrobe_t        strb,
  output logic [LEN_W-1:0] lenOut,
  output logic             echoOut
);

  localparam int ECHO_BITS = WORD_W - 1;
  localparam int MAX_RISES = PREFIX_RISES + WORD_W + ECHO_BITS;
  localparam int RISE_W    = $clog2(MAX_RISES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} ctrlState_e;

  ctrlState_e        state;
  logic [DIV_W-1:0]  halfCnt, halfLen, effHalfIn;
  logic [RISE_W-1:0] riseCnt, totalRises, nextIdx;
  logic [LEN_W-1:0]  lenQ, effLenIn;
  logic              echoQ, gapSecond, halfZero, riseNow, fallNow;

  // clamp requested half period to the minimum phase length
  assign effHalfIn = (halfDiv < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : halfDiv;

  always_comb begin
    effLenIn = LEN_W'(WORD_W);
    if (mode == MODE_SHORT) begin
      if (shortLen == '0)                    effLenIn = LEN_W'(1);
      else if (shortLen > LEN_W'(WORD_W))    effLenIn = LEN_W'(WORD_W);
      else                                   effLenIn = shortLen;
    end
  end

  assign halfZero   = (halfCnt == '0);
  assign totalRises = RISE_W'(PREFIX_RISES) + RISE_W'(lenQ)
                    + (echoQ ? RISE_W'(ECHO_BITS) : '0);
  assign nextIdx    = riseCnt + RISE_W'(1);
  assign riseNow    = (state == ST_RUN) && halfZero && !sclk;
  assign fallNow    = (state == ST_RUN) && halfZero && sclk;

  always_comb begin
    strb         = '0;
    strb.clear   = (state == ST_IDLE) && start;
    strb.capNull = riseNow && (nextIdx == RISE_W'(PREFIX_RISES));
    strb.capData = riseNow && (nextIdx > RISE_W'(PREFIX_RISES))
                 && (nextIdx <= RISE_W'(PREFIX_RISES) + RISE_W'(lenQ));
    strb.capEcho = riseNow && echoQ && (nextIdx > RISE_W'(PREFIX_RISES + WORD_W));
    strb.finish  = fallNow && (riseCnt == totalRises);
  end

  assign busy    = (state != ST_IDLE);
  assign lenOut  = lenQ;
  assign echoOut = echoQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      csN       <= 1'b1;
      sclk      <= 1'b0;
      halfCnt   <= '0;
      halfLen   <= DIV_W'(MIN_HALF);
      riseCnt   <= '0;
      lenQ      <= LEN_W'(WORD_W);
      echoQ     <= 1'b0;
      gapSecond <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            csN     <= 1'b0;
            halfLen <= effHalfIn;
            halfCnt <= effHalfIn - DIV_W'(1);
            riseCnt <= '0;
            lenQ    <= effLenIn;
            echoQ   <= (mode == MODE_ECHO);
          end
        end
        ST_RUN: begin
          if (halfZero) begin
            halfCnt <= halfLen - DIV_W'(1);
            if (!sclk) begin
              sclk    <= 1'b1;
              riseCnt <= nextIdx;
            end else if (riseCnt == totalRises) begin
              sclk      <= 1'b0;
              csN       <= 1'b1;
              gapSecond <= 1'b0;
              state     <= ST_GAP;
            end else begin
              sclk <= 1'b0;
            end
          end else begin
            halfCnt <= halfCnt - DIV_W'(1);
          end
        end
        ST_GAP: begin
          if (halfZero) begin
            if (gapSecond) begin
              state <= ST_IDLE;
            end else begin
              gapSecond <= 1'b1;
              halfCnt   <= halfLen - DIV_W'(1);
            end
          end else begin
            halfCnt <= halfCnt - DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_rd_dpath.sv
module sar_rd_dpath
  import sar_rd_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdi,
  input  rdStrobe_t         strb,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic              echoIn,
  output logic [WORD_W-1:0] result,
  output logic [LEN_W-1:0]  resultLen,
  output logic              resultValid,
  output logic              frameErr,
  output logic              echoErr
);

  localparam int ECHO_BITS = WORD_W - 1;

  logic [WORD_W-1:0]    mainSh, justified;
  logic [ECHO_BITS-1:0] echoSh, mainUpper;
  logic [LEN_W-1:0]     shiftAmt;
  logic                 nullQ;

  assign shiftAmt  = LEN_W'(WORD_W) - lenIn;
  assign justified = mainSh << shiftAmt;

  // the replay arrives low bit first starting at bit 1; line it up bit by bit
  for (genvar gi = 0; gi < ECHO_BITS; gi++) begin : g_upper
    assign mainUpper[gi] = justified[gi + 1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainSh <= '0;
      echoSh <= '0;
      nullQ  <= 1'b0;
    end else if (strb.clear) begin
      mainSh <= '0;
      echoSh <= '0;
      nullQ  <= 1'b0;
    end else begin
      if (strb.capNull) nullQ  <= sdi;
      if (strb.capData) mainSh <= {mainSh[WORD_W-2:0], sdi};
      if (strb.capEcho) echoSh <= {sdi, echoSh[ECHO_BITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result      <= '0;
      resultLen   <= '0;
      resultValid <= 1'b0;
      frameErr    <= 1'b0;
      echoErr     <= 1'b0;
    end else begin
      resultValid <= strb.finish;
      if (strb.finish) begin
        result    <= justified;
        resultLen <= lenIn;
        frameErr  <= nullQ;
        echoErr   <= echoIn && (echoSh != mainUpper);
      end
    end
  end

endmodule

// File: rtl/sar_rd_top.sv
module sar_rd_top
  import sar_rd_pkg::*;
#(
  parameter int WORD_W       = 12,
  parameter int DIV_W        = 8,
  parameter int SYS_MHZ      = 100,
  parameter int MIN_PHASE_NS = 150,
  parameter int PREFIX_RISES = 3,
  localparam int LEN_W       = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [LEN_W-1:0]  shortLen,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic              sdi,
  output logic              csN,
  output logic              sclk,
  output logic              busy,
  output logic [WORD_W-1:0] result,
  output logic [LEN_W-1:0]  resultLen,
  output logic              resultValid,
  output logic              frameErr,
  output logic              echoErr
);

  localparam int RAW_HALF = (SYS_MHZ * MIN_PHASE_NS + 999) / 1000;
  localparam int MIN_HALF = (RAW_HALF < 1) ? 1 : RAW_HALF;

  rdStrobe_t        strb;
  logic [LEN_W-1:0] lenQ;
  logic             echoQ;

  sar_rd_ctrl #(
    .WORD_W(WORD_W), .DIV_W(DIV_W), .MIN_HALF(MIN_HALF),
    .PREFIX_RISES(PREFIX_RISES), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(rdMode_e'(mode)),
    .shortLen(shortLen), .halfDiv(halfDiv), .csN(csN), .sclk(sclk),
    .busy(busy), .strb(strb), .lenOut(lenQ), .echoOut(echoQ)
  );

  sar_rd_dpath #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_dpath (
    .clk(clk), .rstN(rstN), .sdi(sdi), .strb(strb), .lenIn(lenQ),
    .echoIn(echoQ), .result(result), .resultLen(resultLen),
    .resultValid(resultValid), .frameErr(frameErr), .echoErr(echoErr)
  );

endmodule

// File: rtl/sar_rd_chk.sv
module sar_rd_chk #(
  parameter int MIN_HALF = 15,
  parameter int WORD_W   = 12,
  parameter int LEN_W    = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              sclk,
  input logic              busy,
  input logic [WORD_W-1:0] result,
  input logic [LEN_W-1:0]  resultLen,
  input logic              resultValid
);

  logic        sclkQ;
  logic [15:0] run;

  // length of the current clock phase, counted from select-low or the last toggle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      run   <= '0;
    end else begin
      sclkQ <= sclk;
      if (csN)                run <= '0;
      else if (sclk != sclkQ) run <= 16'd1;
      else if (run != '1)     run <= run + 16'd1;
    end
  end

  a_r2_min_half: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && (sclk != sclkQ)) |-> (run >= 16'(MIN_HALF)));

  a_r3_select_low_clock: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !sclk);

  a_r3_clock_gated: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csN && !sclk));

  a_r5_len_range: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> ((resultLen != '0) && (resultLen <= LEN_W'(WORD_W))));

  a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> ((result & ({WORD_W{1'b1}} >> resultLen)) == '0));

  a_r9_valid_on_cs_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> resultValid);

  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

endmodule

bind sar_rd_top sar_rd_chk #(
  .MIN_HALF(MIN_HALF), .WORD_W(WORD_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .busy(busy),
  .result(result), .resultLen(resultLen), .resultValid(resultValid)
);

// File: tb/test_sar_rd_top.sv
module test_sar_rd_top;

  localparam int BENCH_MIN_HALF = 3; // 150 ns at 20 MHz

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  shortLen = 4'd12;
  logic [7:0]  halfDiv = 8'd4;
  logic        sdi = 1'b1;
  logic        csN, sclk, busy, resultValid, frameErr, echoErr;
  logic [11:0] result;
  logic [3:0]  resultLen;

  sar_rd_top #(.SYS_MHZ(20)) i_sar_rd_top (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .shortLen(shortLen),
    .halfDiv(halfDiv), .sdi(sdi), .csN(csN), .sclk(sclk), .busy(busy),
    .result(result), .resultLen(resultLen), .resultValid(resultValid),
    .frameErr(frameErr), .echoErr(echoErr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // converter model: counts falling clock edges since select went low
  logic [11:0] mWord = '0;
  logic        mNull = 1'b0;
  int          mFlipAt = 0;
  int          fallCnt = 0;

  always @(posedge csN or negedge sclk) begin
    if (csN === 1'b1) begin
      fallCnt = 0;
      sdi = 1'b1;
    end else begin
      fallCnt++;
      if (fallCnt < 2)        sdi = 1'b1;
      else if (fallCnt == 2)  sdi = mNull;
      else if (fallCnt <= 14) sdi = mWord[14 - fallCnt];
      else if (fallCnt <= 25) sdi = mWord[fallCnt - 14] ^ (fallCnt == mFlipAt);
      else                    sdi = 1'b0;
    end
  end

  // per-clock waveform monitor
  int       expHalf = 4;
  int       expRises = 15;
  int       curHalf = 4;
  int       gapHalf = 4;
  int       segLen = 0;
  int       riseCount = 0;
  int       framesSeen = 0;
  logic [1:0] prevKey = 2'b10;
  logic     prevValid = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      logic [1:0] key;
      key = {csN, sclk};
      if (key == 2'b11) chk(0, "R3", "sclk high while deselected", 1, 0);
      if (key != prevKey) begin
        if (prevKey[1] == 1'b0)
          chk(segLen == curHalf, "R2", "clock phase length", segLen, curHalf);
        if (prevKey[1] == 1'b1 && key[1] == 1'b0) begin
          if (framesSeen > 0)
            chk(segLen >= 2 * gapHalf, "R8", "select high gap", segLen, 2 * gapHalf);
          chk(key[0] == 1'b0, "R3", "sclk at select fall", key[0], 0);
          framesSeen++;
          riseCount = 0;
          curHalf = expHalf;
        end
        if (prevKey == 2'b00 && key == 2'b01) riseCount++;
        if (prevKey[1] == 1'b0 && key[1] == 1'b1) begin
          chk(riseCount == expRises, "R3", "rising edges per frame", riseCount, expRises);
          chk(resultValid == 1'b1, "R9", "valid with select rise", resultValid, 1);
          gapHalf = curHalf;
        end
        segLen = 1;
      end else begin
        segLen++;
      end
      if (resultValid && !(prevKey[1] == 1'b0 && key[1] == 1'b1))
        chk(0, "R9", "valid outside select rise", 1, 0);
      if (resultValid && prevValid)
        chk(0, "R9", "valid longer than one cycle", 1, 0);
      prevKey = key;
      prevValid = resultValid;
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      finishRun();
    end
  end

  int framesAsked = 0;

  task automatic runFrame(input int md, input int sl, input int hd,
                          input logic [11:0] word, input bit nullHi,
                          input int flipAt, input bit midStart);
    int effLen, h, waitCnt;
    logic [11:0] expRes;
    bit expEcho;
    h = (hd < BENCH_MIN_HALF) ? BENCH_MIN_HALF : hd;
    if (md == 1) effLen = (sl == 0) ? 1 : ((sl > 12) ? 12 : sl);
    else         effLen = 12;
    expRes  = (word >> (12 - effLen)) << (12 - effLen);
    expEcho = (md == 2) && (flipAt != 0);
    mWord = word; mNull = nullHi; mFlipAt = flipAt;
    expHalf = h;
    expRises = (md == 2) ? 26 : 3 + effLen;
    mode = md[1:0]; shortLen = sl[3:0]; halfDiv = hd[7:0];
    while (busy) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    framesAsked++;
    if (midStart) begin
      repeat (10 * h) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitCnt = 0;
    while (!resultValid && waitCnt < 5000) begin
      @(negedge clk);
      waitCnt++;
    end
    chk(resultValid, "R9", "result strobe seen", resultValid, 1);
    if (md == 1)
      chk(result == expRes, "R5", "short result", result, expRes);
    else
      chk(result == expRes, "R4", "full result", result, expRes);
    chk(resultLen == effLen[3:0], (md == 1) ? "R5" : "R4", "result length", resultLen, effLen);
    chk(frameErr == nullHi, "R6", "framing flag", frameErr, nullHi);
    chk(echoErr == expEcho, "R7", "echo flag", echoErr, expEcho);
    // values must hold after the strobe
    @(negedge clk);
    chk(result == expRes, "R9", "result held", result, expRes);
    if (midStart) begin
      repeat (6 * h) @(negedge clk);
      chk(framesSeen == framesAsked, "R8", "start while busy ignored", framesSeen, framesAsked);
      chk(csN == 1'b1, "R8", "no extra frame", csN, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(csN == 1'b1, "R1", "csN in reset", csN, 1);
    chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(resultValid == 1'b0, "R1", "valid in reset", resultValid, 0);
    chk(result == 12'h000, "R1", "result in reset", result, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(csN == 1'b1 && busy == 1'b0, "R1", "idle after reset", {csN, busy}, 2);

    // R4 full reads, several patterns
    runFrame(0, 12, 4, 12'hA5C, 0, 0, 0);
    runFrame(0, 12, 4, 12'hFFF, 0, 0, 0);
    runFrame(0, 12, 4, 12'h000, 0, 0, 0);
    runFrame(0, 12, 7, 12'h800, 0, 0, 0);
    runFrame(3, 12, 4, 12'h7FF, 0, 0, 0);     // R4 mode 3 behaves as full
    // R2 clamp of short half periods
    runFrame(0, 12, 0, 12'h3C5, 0, 0, 0);
    runFrame(0, 12, 1, 12'h96A, 0, 0, 0);
    // R5 short cycling
    runFrame(1, 4, 4, 12'hBCD, 0, 0, 0);
    runFrame(1, 8, 5, 12'h5A3, 0, 0, 0);
    runFrame(1, 3, 4, 12'hFFF, 0, 0, 0);
    runFrame(1, 0, 4, 12'h801, 0, 0, 0);
    runFrame(1, 15, 4, 12'h123, 0, 0, 0);
    // R6 framing error and recovery
    runFrame(0, 12, 4, 12'h456, 1, 0, 0);
    runFrame(1, 5, 4, 12'h456, 1, 0, 0);
    runFrame(0, 12, 4, 12'h456, 0, 0, 0);
    // R7 echo checks
    runFrame(2, 12, 4, 12'hC3A, 0, 0, 0);
    runFrame(2, 12, 4, 12'hC3A, 0, 20, 0);
    runFrame(2, 12, 3, 12'h001, 0, 25, 0);
    runFrame(2, 12, 4, 12'hFFE, 0, 0, 0);
    runFrame(0, 12, 4, 12'hC3A, 0, 20, 0);   // flip past the word: no effect
    // R8 start while busy
    runFrame(0, 12, 4, 12'h6B9, 0, 0, 1);
    runFrame(2, 12, 4, 12'h2D4, 0, 0, 1);

    repeat (20) @(negedge clk);
    finishRun();
  end

endmodule